// File: doc/BRIEF.md
# Zone Alarm Frame Validator

This block sits behind the demodulator of a wireless alarm receiver. The demodulator has already turned the radio signal back into a clean logic-level serial line. The block treats that line as an asynchronous serial link and oversamples it at 16 times the bit rate. It assembles each frame and keeps only frames whose eight data bits carry even parity and whose stop bit is high. From each frame that passes, it takes the seven-bit zone number.

A single good frame is not trusted. An alarm is declared only when three valid frames in a row carry the same zone number. The block then pulses an alarm strobe for one clock and latches the zone number for the display. A parity or framing fault wipes the vote and raises a one-cycle error flag. The bit rate comes from a clock-divisor parameter, so simulation can run at a fast rate while hardware runs at 300 bit/s.

Top module: `alarm_frame_validator`

## Requirements
- R1: While reset is high and after its release, zone_addr is 0 and alarm_strobe and frame_err are low until a frame completes.
- R2: A frame is one low start bit, then 8 data bits sent least significant bit first, then one high stop bit. Each bit lasts OVERSAMPLE × CLKS_PER_TICK clocks. Data bits 6:0 hold the zone number and data bit 7 holds the parity bit.
- R3: A low level that does not last until the middle of the start bit is a glitch. It produces no strobe and no error, and it leaves the vote in progress untouched.
- R4: The count of ones across all 8 data bits must be even. A frame that fails this check is dropped and frame_err pulses for one clock.
- R5: A stop bit that reads low drops the frame and pulses frame_err. No new start bit is accepted until the line has returned high, so a long low break yields exactly one error.
- R6: When three consecutive valid frames carry the same zone number, alarm_strobe pulses. zone_addr shows that number from the same clock on.
- R7: A valid frame whose zone number differs from the zone number being voted on restarts the vote, with the new number counted as the first vote. It raises no strobe and no error.
- R8: A parity or framing error clears the vote, so three further matching valid frames are needed.
- R9: zone_addr changes only in a clock where alarm_strobe is high, and holds its value otherwise.
- R10: After a confirmation the vote starts from zero, so a continuous stream of one zone number confirms on every third frame.
- R11: alarm_strobe never stays high for two clocks in a row and is never high in the same clock as frame_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serial_in | input | 1 | Squared-up demodulated serial line, idle high |
| zone_addr | output | 7 | Last confirmed zone number |
| alarm_strobe | output | 1 | One-clock pulse when a zone is confirmed |
| frame_err | output | 1 | One-clock pulse when a frame fails parity or has a low stop bit |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe is one cycle wide and never coincides with the error flag;
- the zone register moves only with the strobe;
- an error follows a completed frame and leaves the vote count at zero;
- a strobe follows a full vote;
- the receiver enters data sampling only from a start bit that was low at mid-bit, and stays in its break state while the line is low.

Other behaviour only shows in the bench's scenarios against its own queue model:
- the zone numbers decoded from different bit patterns;
- the restart of a vote when the zone number changes;
- the clearing of a vote by parity and framing faults;
- glitch rejection that leaves a vote in progress intact;
- the every-third-frame cadence of a continuous alarm.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              stop_ok;
    } rx_frame_t;

    // even parity across the full data byte (address plus parity bit)
    function automatic logic parity_even(input logic [DATA_W-1:0] d);
        return ~(^d);
    endfunction

    function automatic logic [ADDR_W-1:0] zone_of(input logic [DATA_W-1:0] d);
        return d[ADDR_W-1:0];
    endfunction

endpackage

// File: rtl/alarm_tick_gen.sv
module alarm_tick_gen #(
    parameter int CLKS_PER_TICK = 26042
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [TW-1:0] LAST = TW'(CLKS_PER_TICK - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == LAST);
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/alarm_uart_rx.sv
module alarm_uart_rx
    import alarm_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      serial_in,
    output logic      frame_vld,
    output rx_frame_t frame
);
    localparam int OS_W = $clog2(OVERSAMPLE);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVERSAMPLE - 1);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OVERSAMPLE / 2 - 1);
    localparam int BI_W = $clog2(DATA_W);
    localparam logic [BI_W-1:0] BI_LAST = BI_W'(DATA_W - 1);

    logic              rxd_meta, rxd_s;
    rx_state_e         state;
    logic [OS_W-1:0]   os_cnt;
    logic [BI_W-1:0]   bit_idx;
    logic [DATA_W-1:0] shreg;

    // two-flop synchronizer, idle level high
    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_meta <= 1'b1;
            rxd_s    <= 1'b1;
        end else begin
            rxd_meta <= serial_in;
            rxd_s    <= rxd_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            os_cnt    <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (tick && !rxd_s) begin
                        state  <= RX_START;
                        os_cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (os_cnt == OS_MID) begin
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            state   <= rxd_s ? RX_IDLE : RX_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (os_cnt == OS_LAST) begin
                            os_cnt <= '0;
                            shreg  <= {rxd_s, shreg[DATA_W-1:1]};
                            if (bit_idx == BI_LAST) state <= RX_STOP;
                            else                    bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (os_cnt == OS_LAST) begin
                            os_cnt        <= '0;
                            frame_vld     <= 1'b1;
                            frame.data    <= shreg;
                            frame.stop_ok <= rxd_s;
                            state         <= rxd_s ? RX_IDLE : RX_BREAK;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_BREAK: begin
                    if (rxd_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R3: data sampling begins only if the start bit was still low at mid-bit
    a_r3_start_mid_low: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == RX_START && state == RX_DATA) |-> !$past(rxd_s));

    // R5: while the line stays low after a bad stop bit, no new frame may begin
    a_r5_break_hold: assert property (@(posedge clk) disable iff (rst)
        (state == RX_BREAK && !rxd_s) |=> state == RX_BREAK);

    // R2: a frame is delivered only at the end of the stop bit
    a_r2_frame_from_stop: assert property (@(posedge clk) disable iff (rst)
        frame_vld |-> $past(state) == RX_STOP);

endmodule

// File: rtl/alarm_vote.sv
module alarm_vote
    import alarm_pkg::*;
#(
    parameter int VOTES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  rx_frame_t         frame,
    output logic [ADDR_W-1:0] zone_addr,
    output logic              alarm_strobe,
    output logic              frame_err
);
    // VOTES must be at least 2
    localparam int CNT_W = $clog2(VOTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VOTES - 1);

    logic [ADDR_W-1:0] cand;
    logic [CNT_W-1:0]  count;
    logic              good;
    logic [ADDR_W-1:0] addr_in;

    always_comb begin
        good    = frame.stop_ok && parity_even(frame.data);
        addr_in = zone_of(frame.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand         <= '0;
            count        <= '0;
            zone_addr    <= '0;
            alarm_strobe <= 1'b0;
            frame_err    <= 1'b0;
        end else begin
            alarm_strobe <= 1'b0;
            frame_err    <= 1'b0;
            if (frame_vld) begin
                if (!good) begin
                    frame_err <= 1'b1;
                    count     <= '0;
                end else if (count == '0 || addr_in != cand) begin
                    cand  <= addr_in;
                    count <= CNT_W'(1);
                end else if (count == CNT_LAST) begin
                    alarm_strobe <= 1'b1;
                    zone_addr    <= addr_in;
                    count        <= '0;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // R11: strobe is a single clock wide
    a_r11_strobe_single: assert property (@(posedge clk) disable iff (rst)
        alarm_strobe |=> !alarm_strobe);

    // R11: strobe and error never together
    a_r11_strobe_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(alarm_strobe && frame_err));

    // R9: displayed zone moves only with the strobe
    a_r9_zone_hold: assert property (@(posedge clk) disable iff (rst)
        !alarm_strobe |-> $stable(zone_addr));

    // R4: an error only follows a completed frame
    a_r4_err_after_frame: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(frame_vld));

    // R8: an error leaves the vote empty
    a_r8_err_clears_vote: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> count == '0);

    // R6: a strobe needs the previous votes already collected
    a_r6_strobe_after_votes: assert property (@(posedge clk) disable iff (rst)
        alarm_strobe |-> ($past(count) == CNT_LAST && $past(frame_vld)));

endmodule

// File: rtl/alarm_frame_validator.sv
module alarm_frame_validator
    import alarm_pkg::*;
#(
    parameter int CLKS_PER_TICK = 26042,
    parameter int OVERSAMPLE    = 16,
    parameter int VOTES         = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_in,
    output logic [ADDR_W-1:0] zone_addr,
    output logic              alarm_strobe,
    output logic              frame_err
);
    logic      tick;
    logic      frame_vld;
    rx_frame_t frame;

    alarm_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    alarm_uart_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .serial_in (serial_in),
        .frame_vld (frame_vld),
        .frame     (frame)
    );

    alarm_vote #(.VOTES(VOTES)) u_vote (
        .clk          (clk),
        .rst          (rst),
        .frame_vld    (frame_vld),
        .frame        (frame),
        .zone_addr    (zone_addr),
        .alarm_strobe (alarm_strobe),
        .frame_err    (frame_err)
    );
endmodule

// File: tb/tb_alarm_frame_validator.sv
module tb_alarm_frame_validator;
    localparam int CPT    = 4;
    localparam int OS     = 16;
    localparam int BIT_CY = CPT * OS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_in = 1'b1;
    logic [6:0] zone_addr;
    logic       alarm_strobe;
    logic       frame_err;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    // observed event counters
    int seen_alarm = 0;
    int seen_err = 0;
    logic [6:0] prev_zone = '0;
    logic prev_strobe = 1'b0;

    // reference model
    int exp_alarm = 0;
    int exp_err = 0;
    int model_zone = 0;
    int votes[$];

    always #4 clk = ~clk;   // 125 MHz

    alarm_frame_validator #(.CLKS_PER_TICK(CPT), .OVERSAMPLE(OS), .VOTES(3)) dut (
        .clk(clk), .rst(rst), .serial_in(serial_in),
        .zone_addr(zone_addr), .alarm_strobe(alarm_strobe), .frame_err(frame_err)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model's invariants
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (alarm_strobe) seen_alarm++;
            if (frame_err)    seen_err++;
            check("R11 strobe with error", int'(alarm_strobe && frame_err), 0);
            check("R11 strobe width", int'(alarm_strobe && prev_strobe), 0);
            if (!alarm_strobe) check("R9 zone held", zone_addr, prev_zone);
            prev_zone   = zone_addr;
            prev_strobe = alarm_strobe;
        end
    end

    task automatic drive_bit(input logic b);
        serial_in = b;
        repeat (BIT_CY) @(negedge clk);
    endtask

    // send one frame; bad_par flips the parity bit, bad_stop drives a low stop bit
    task automatic send(input int addr, input bit bad_par, input bit bad_stop, input string req);
        logic [6:0] a;
        logic [7:0] d;
        a = 7'(addr);
        d = {(^a) ^ bad_par, a};
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        drive_bit(!bad_stop);
        if (bad_stop) drive_bit(1'b0);   // extended low break
        drive_bit(1'b1);
        // model update
        if (bad_par || bad_stop) begin
            exp_err++;
            votes.delete();
        end else begin
            if (votes.size() > 0 && votes[$] != addr) votes.delete();
            votes.push_back(addr);
            if (votes.size() == 3) begin
                exp_alarm++;
                model_zone = addr;
                votes.delete();
            end
        end
        check({req, " alarm count"}, seen_alarm, exp_alarm);
        check({req, " error count"}, seen_err, exp_err);
        check({req, " zone"}, zone_addr, model_zone);
    endtask

    task automatic glitch(input int ticks);
        serial_in = 1'b0;
        repeat (ticks * CPT) @(negedge clk);
        serial_in = 1'b1;
        repeat (3 * BIT_CY) @(negedge clk);
        check("R3 glitch alarm count", seen_alarm, exp_alarm);
        check("R3 glitch error count", seen_err, exp_err);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset zone", zone_addr, 0);
        check("R1 reset strobe", alarm_strobe, 0);
        check("R1 reset err", frame_err, 0);
        rst = 1'b0;
        repeat (BIT_CY) @(negedge clk);
        check("R1 idle zone", zone_addr, 0);
        check("R1 idle counts", seen_alarm + seen_err, 0);

        // R6 / R2: basic confirmation across several bit patterns
        for (int k = 0; k < 3; k++) send(7'h15, 0, 0, "R6 zone 15h");
        for (int k = 0; k < 3; k++) send(7'h7F, 0, 0, "R2 zone 7Fh");
        for (int k = 0; k < 3; k++) send(7'h00, 0, 0, "R2 zone 00h");
        for (int k = 0; k < 3; k++) send(7'h2A, 0, 0, "R2 zone 2Ah");

        // R7: changing zone restarts the vote
        send(7'h11, 0, 0, "R7 first");
        send(7'h11, 0, 0, "R7 second");
        send(7'h22, 0, 0, "R7 switch");
        send(7'h22, 0, 0, "R7 follow");
        send(7'h22, 0, 0, "R7 confirm");

        // R4 / R8: parity fault clears the vote
        send(7'h33, 0, 0, "R8 parity pre1");
        send(7'h33, 0, 0, "R8 parity pre2");
        send(7'h33, 1, 0, "R4 parity bad");
        send(7'h33, 0, 0, "R8 parity post1");
        send(7'h33, 0, 0, "R8 parity post2");
        send(7'h33, 0, 0, "R8 parity post3");

        // R5 / R8: framing fault with long break clears the vote
        send(7'h4C, 0, 0, "R8 stop pre1");
        send(7'h4C, 0, 0, "R8 stop pre2");
        send(7'h4C, 0, 1, "R5 stop low");
        send(7'h4C, 0, 0, "R8 stop post1");
        send(7'h4C, 0, 0, "R8 stop post2");
        send(7'h4C, 0, 0, "R8 stop post3");

        // R10: continuous stream confirms on every third frame
        for (int k = 0; k < 6; k++) send(7'h5A, 0, 0, "R10 stream");

        // R3: short low pulses are ignored and keep the vote in progress
        send(7'h09, 0, 0, "R3 pre1");
        send(7'h09, 0, 0, "R3 pre2");
        glitch(3);
        glitch(6);
        send(7'h09, 0, 0, "R3 post");

        summary();
    end
endmodule